// File: doc/BRIEF.md
# Mixed-Signedness Integer Multiplier

This unit multiplies two XLEN-bit integers (64 by default) over several cycles. Each operand is read as signed or unsigned according to a 2-bit selector, and the full 2×XLEN-bit product is formed. The unit returns either the low or the high XLEN bits of that product. A word-mode flag changes the operation: only the low WLEN bits (32 by default) of each operand are used, both are read as signed, and the low WLEN bits of the product are returned sign-extended to XLEN bits.

Operands enter through a valid/ready request port. The unit takes a request only while it is idle, so `in_ready` is low from the accept edge until the cycle after its result has been taken. The result leaves through a valid/ready response port. While `out_ready` is low, `out_valid` and `out_data` hold, and this back-pressure stalls the unit. After the response handshake, `out_data` keeps its value until the next request is accepted.

Internally the operands are reduced to magnitudes. They are then multiplied by a radix-2 shift-and-add loop, one partial product per cycle. Full-width operations take XLEN steps and word operations take WLEN steps. The sign of the result is applied at the end.

Top module: `imul_unit`

## Requirements
- R1: With `in_word`=0 and `in_op[1:0]`=00, `out_data` is bits XLEN-1..0 of the product, with both operands read as signed. This low half equals the low half of the unsigned product.
- R2: With `in_word`=0 and `in_op[1:0]`=01, `out_data` is bits 2×XLEN-1..XLEN of the signed×signed product.
- R3: With `in_word`=0 and `in_op[1:0]`=10, `out_data` is the high half of the product of `in_a` read as signed and `in_b` read as unsigned.
- R4: With `in_word`=0 and `in_op[1:0]`=11, `out_data` is the high half of the unsigned×unsigned product.
- R5: `in_op[2]` has no effect. A code 1xx gives the same result as code 0xx.
- R6: With `in_word`=1, `out_data` is the low WLEN bits of the signed product of `in_a[WLEN-1:0]` and `in_b[WLEN-1:0]`, sign-extended to XLEN bits, for any value of `in_op`.
- R7: `out_valid` rises exactly XLEN clock edges after the accept edge in full-width mode, and exactly WLEN edges after it in word mode.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged.
- R9: After reset `in_ready`=1, `out_valid`=0 and `out_data`=0. `in_ready` is low from the accept edge until the response handshake, and high in the cycle after that handshake. `in_ready` and `out_valid` are never high together.
- R10: After the response handshake, `out_data` keeps its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle; a request is taken on this edge |
| in_op | input | 3 | Operation select; bits 1..0 choose half and signedness |
| in_word | input | 1 | Word mode |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | XLEN | Result |

## Verification
The response handshake and a new request can fall in the same cycle. The bench provokes this by raising `in_valid` with fresh operands in the same cycle that `out_ready` takes the pending result. At that edge the new request must not be taken, since `in_ready` is still low. In the following cycle `in_ready` must be high, `out_valid` low and `out_data` must still carry the old result. The new request is then taken one edge later, and both its latency and its product are checked against the integer model.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    SEL_LO_SS = 2'b00,
    SEL_HI_SS = 2'b01,
    SEL_HI_SU = 2'b10,
    SEL_HI_UU = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } state_e;
endpackage

// File: rtl/imul_prep.sv
module imul_prep
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  sel_e            sel,
  input  logic            word,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg,
  output logic            hi
);
  localparam int EXT = XLEN - WLEN;

  logic [XLEN-1:0] a_ext, b_ext;
  logic            a_sgn, b_sgn, a_neg, b_neg;

  always_comb begin
    a_ext = word ? {{EXT{a[WLEN-1]}}, a[WLEN-1:0]} : a;
    b_ext = word ? {{EXT{b[WLEN-1]}}, b[WLEN-1:0]} : b;
    a_sgn = word || (sel != SEL_HI_UU);
    b_sgn = word || (sel == SEL_LO_SS) || (sel == SEL_HI_SS);
    a_neg = a_sgn && a_ext[XLEN-1];
    b_neg = b_sgn && b_ext[XLEN-1];
    mag_a = a_neg ? (~a_ext + XLEN'(1)) : a_ext;
    mag_b = b_neg ? (~b_ext + XLEN'(1)) : b_ext;
    neg   = a_neg ^ b_neg;
    hi    = !word && (sel != SEL_LO_SS);
  end
endmodule

// File: rtl/imul_core.sv
module imul_core #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [XLEN-1:0]   mag_a,
  input  logic [XLEN-1:0]   mag_b,
  output logic [2*XLEN-1:0] acc
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   mcand_q, acc_q;
  logic [XLEN-1:0] mplier_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load) begin
      mcand_q  <= {{XLEN{1'b0}}, mag_a};
      mplier_q <= mag_b;
      acc_q    <= '0;
    end else if (step) begin
      acc_q    <= acc_q + (mplier_q[0] ? mcand_q : '0);
      mcand_q  <= {mcand_q[PW-2:0], 1'b0};
      mplier_q <= {1'b0, mplier_q[XLEN-1:1]};
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/imul_finish.sv
module imul_finish #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [2*XLEN-1:0] acc,
  input  logic              neg,
  input  logic              hi,
  input  logic              word,
  output logic [XLEN-1:0]   data
);
  localparam int PW  = 2 * XLEN;
  localparam int EXT = XLEN - WLEN;

  logic [PW-1:0]   prod;
  logic [XLEN-1:0] half;

  always_comb begin
    prod = neg ? (~acc + PW'(1)) : acc;
    half = hi ? prod[PW-1:XLEN] : prod[XLEN-1:0];
    data = word ? {{EXT{prod[WLEN-1]}}, prod[WLEN-1:0]} : half;
  end
endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic            in_word,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);
  localparam int CW = $clog2(XLEN);

  state_e          state_q;
  logic [CW-1:0]   cnt_q;
  logic            neg_q, hi_q, word_q;
  logic            accept, step;
  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_d, hi_d;
  logic [2*XLEN-1:0] acc;
  sel_e            sel;
  logic            unused_op_hi;

  assign sel          = sel_e'(in_op[1:0]);
  assign unused_op_hi = in_op[2];
  assign in_ready     = (state_q == ST_IDLE);
  assign out_valid    = (state_q == ST_DONE);
  assign accept       = in_valid && in_ready;
  assign step         = (state_q == ST_RUN);

  imul_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .a(in_a), .b(in_b), .sel(sel), .word(in_word),
    .mag_a(mag_a), .mag_b(mag_b), .neg(neg_d), .hi(hi_d)
  );

  imul_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .mag_a(mag_a), .mag_b(mag_b), .acc(acc)
  );

  imul_finish #(.XLEN(XLEN), .WLEN(WLEN)) u_finish (
    .acc(acc), .neg(neg_q), .hi(hi_q), .word(word_q), .data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      hi_q    <= 1'b0;
      word_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          cnt_q   <= in_word ? CW'(WLEN - 1) : CW'(XLEN - 1);
          neg_q   <= neg_d;
          hi_q    <= hi_d;
          word_q  <= in_word;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imul_unit_chk.sv
module imul_unit_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_word,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data
);
  localparam int LW = $clog2(XLEN + 1) + 1;

  logic [LW-1:0] lat_q, exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
      exp_q <= '0;
    end else if (in_valid && in_ready) begin
      lat_q <= '0;
      exp_q <= in_word ? LW'(WLEN) : LW'(XLEN);
    end else if (!in_ready && !out_valid) begin
      lat_q <= lat_q + LW'(1);
    end
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == exp_q));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> $stable(out_data));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_data));
endmodule

bind imul_unit imul_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/imul_unit_test.sv
module imul_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 64;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = 3'b000;
  logic          in_word = 1'b0;
  logic [XW-1:0] in_a = '0;
  logic [XW-1:0] in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [XW-1:0] out_data;

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD / 2) clk = ~clk;

  imul_unit #(.XLEN(XW), .WLEN(WW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] ref_mul(logic [63:0] a, logic [63:0] b,
                                          logic [2:0] op, logic word);
    logic [127:0] ea, eb, p;
    if (word) begin
      ea = {{96{a[31]}}, a[31:0]};
      eb = {{96{b[31]}}, b[31:0]};
      p  = ea * eb;
      return {{32{p[31]}}, p[31:0]};
    end
    ea = (op[1:0] == 2'b11) ? {64'b0, a} : {{64{a[63]}}, a};
    eb = (op[1:0] <= 2'b01) ? {{64{b[63]}}, b} : {64'b0, b};
    p  = ea * eb;
    return (op[1:0] == 2'b00) ? p[63:0] : p[127:64];
  endfunction

  function automatic string tag_of(logic [2:0] op, logic word);
    if (word) return "R6";
    if (op[2]) return "R5";
    case (op[1:0])
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [63:0] corner(int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      5: return 64'h0000_0000_8000_0000;
      6: return 64'h0000_0000_7FFF_FFFF;
      7: return 64'h0000_0000_FFFF_FFFF;
      8: return 64'h1234_5678_9ABC_DEF0;
      default: return 64'h8000_0000_0000_0001;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic next_rand(output logic [63:0] v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    v = rng;
  endtask

  // Called at a negedge; returns at the negedge after the accept edge.
  task automatic issue(input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] op, input logic word);
    in_a = a; in_b = b; in_op = op; in_word = word; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R9 busy after accept", 64'(in_ready), 64'd0);
  endtask

  task automatic collect(input logic [63:0] exp, input int lat_exp,
                         input string tag, input int stall, input bit release_out);
    int lat = 0;
    while (!out_valid && lat < 300) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk(lat == lat_exp, "R7 latency", 64'(lat), 64'(lat_exp));
    chk(out_data == exp, tag, out_data, exp);
    for (int s = 0; s < stall; s++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid && out_data == exp, "R8 hold under back-pressure", out_data, exp);
    end
    if (release_out) begin
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0;
      chk(!out_valid && in_ready, "R9 idle after handshake",
          64'({out_valid, in_ready}), 64'b01);
      chk(out_data == exp, "R10 keep after handshake", out_data, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input logic [2:0] op, input logic word, input int stall);
    issue(a, b, op, word);
    collect(ref_mul(a, b, op, word), word ? WW : XW, tag_of(op, word), stall, 1'b1);
  endtask

  task automatic overlap(input logic [63:0] a1, input logic [63:0] b1,
                         input logic [63:0] a2, input logic [63:0] b2,
                         input logic [2:0] op2, input logic word2);
    logic [63:0] e1;
    e1 = ref_mul(a1, b1, 3'b001, 1'b0);
    issue(a1, b1, 3'b001, 1'b0);
    collect(e1, XW, "R2", 0, 1'b0);
    in_a = a2; in_b = b2; in_op = op2; in_word = word2;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R9 request refused in handshake cycle",
        64'({in_ready, out_valid}), 64'b10);
    chk(out_data == e1, "R10 old result kept", out_data, e1);
    issue(a2, b2, op2, word2);
    collect(ref_mul(a2, b2, op2, word2), word2 ? WW : XW, tag_of(op2, word2), 1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(in_ready && !out_valid, "R9 reset handshake state",
        64'({in_ready, out_valid}), 64'b10);
    chk(out_data == '0, "R9 reset data", out_data, 64'd0);

    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        for (int o = 0; o < 4; o++)
          run(corner(i), corner(j), 3'(o), 1'b0, (i + j + o) % 3);
        run(corner(i), corner(j), 3'((i + j) % 8), 1'b1, (i + j) % 2);
        run(corner(i), corner(j), 3'(4 + (i + j) % 4), 1'b0, 0);
      end
    end

    for (int k = 0; k < 150; k++) begin
      next_rand(ra);
      next_rand(rb);
      for (int o = 0; o < 4; o++)
        run(ra, rb, 3'(o), 1'b0, k % 2);
      run(ra, rb, 3'(k % 8), 1'b1, 0);
    end

    overlap(corner(3), corner(2), corner(8), corner(9), 3'b010, 1'b0);
    overlap(corner(4), corner(4), corner(5), corner(7), 3'b011, 1'b1);
    overlap(corner(9), corner(8), corner(3), corner(3), 3'b100, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule